// File: doc/BRIEF.md
# Region-Decoded Shared-Pool Translation Buffer

This block caches virtual-to-physical translations for two page sizes in one set-associative array. The page size of an access is not looked up. It follows from the two top bits of the virtual address, because the address space is cut into fixed regions and each region uses a single page size. The size is therefore known before the array is read. It selects which address bits form the set index and which form the tag. Every way of every set can then hold an entry of either size, and no capacity is set aside for one size.

A lookup presents a virtual address. One cycle later the block returns a hit flag and the translated physical address. A fill installs a frame number for a virtual page. If that page is already cached, the fill overwrites the matching way. Otherwise it writes the way chosen by a per-set tree pseudo-LRU. A flush empties the whole array in one cycle. Page walking, permission checks and address-space tags are left to the surrounding logic.

Top module: `mtlb_top`

## Requirements
- R1: The region code is `va[47:46]`. Codes 00 and 01 select 4 KB pages and code 10 selects 2 MB pages. Code 11 is reserved: a lookup there always misses, and a fill there changes nothing.
- R2: A 4 KB access takes its set index from `va[15:12]` and its tag from `va[47:16]`. A 2 MB access takes its set index from `va[24:21]` and its tag from `va[47:25]`, zero-extended to 32 bits.
- R3: A hit returns a 40-bit physical address. For 4 KB it is `{pfn[27:0], va[11:0]}`. For 2 MB it is `{pfn[27:9], va[20:0]}`. A miss returns 0.
- R4: Each entry stores its page-size bit, and a lookup matches only entries of its own size. A 4 KB entry never answers a 2 MB lookup, even when its tag and index bits are equal, and a 2 MB entry never answers a 4 KB lookup.
- R5: All 4 ways of a set hold entries of any size in any mix. Two 4 KB pages and two 2 MB pages with the same set index are all resident at once.
- R6: A fill is visible to lookups from the next cycle on. A lookup issued in the same cycle as a fill sees the contents from before that fill.
- R7: A fill of a page that is already resident rewrites that way with the new frame number. It does not allocate a second way, so a lookup never matches more than one way.
- R8: Each set keeps 3 tree bits. The root bit picks the pair of ways (0 = ways 0/1, 1 = ways 2/3), and the pair bit picks the way within that pair (0 = lower way). All bits reset to 0, so the first victim is way 0. A fill of a page that is not resident writes the victim way.
- R9: A lookup hit and a fill both update their set's tree bits so that they point away from the way used. When both hit the same set in the same cycle, the lookup's update is applied first and the fill's update second. The victim for a fill is taken from the tree bits as they stood at the start of that cycle.
- R10: A flush clears every valid bit in one cycle, so a lookup in the following cycle misses. A fill in the same cycle as a flush is dropped. A lookup in the flush cycle still sees the old contents. The tree bits are kept across a flush.
- R11: Reset is synchronous and active-high. After reset every entry is invalid, and `rsp_valid`, `rsp_hit` and `rsp_pa` are all 0. `rsp_valid` follows `lk_valid` by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 48 | Lookup virtual address |
| fill_valid | input | 1 | Fill request this cycle |
| fill_va | input | 48 | Virtual address of the page to install |
| fill_pfn | input | 28 | Physical frame number for the page |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pa | output | 40 | Translated physical address, 0 on miss |

## Verification
The in-line assertions watch the following on every cycle:
- a lookup never matches two ways;
- the reserved region never hits;
- a lookup right after a flush misses;
- a 2 MB hit keeps the low 21 address bits;
- a fill leaves its own way off the next victim slot of that set.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- separation by page size when tag bits happen to line up;
- a mixed-size set;
- same-cycle fill and lookup ordering;
- the exact order of victims under interleaved hits;
- frame numbers returned after a refill.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;

  typedef enum logic {
    PG_SMALL = 1'b0,
    PG_LARGE = 1'b1
  } pg_size_e;

  localparam logic [1:0] RGN_LARGE    = 2'b10;
  localparam logic [1:0] RGN_RESERVED = 2'b11;

endpackage

// File: rtl/mtlb_region_dec.sv
module mtlb_region_dec #(
  parameter int VA_W  = 48,
  parameter int IDX_W = 4,
  parameter int OFF_S = 12,
  parameter int OFF_L = 21,
  parameter int TAG_W = VA_W - OFF_S - IDX_W
) (
  input  logic [VA_W-1:0]        va,
  output mtlb_pkg::pg_size_e     size,
  output logic                   rsvd,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       tag
);
  localparam int TAGL_W = VA_W - OFF_L - IDX_W;

  logic [1:0] region;

  assign region = va[VA_W-1 -: 2];
  assign rsvd   = (region == mtlb_pkg::RGN_RESERVED);
  assign size   = (region == mtlb_pkg::RGN_LARGE) ? mtlb_pkg::PG_LARGE : mtlb_pkg::PG_SMALL;

  always_comb begin
    if (size == mtlb_pkg::PG_LARGE) begin
      idx = va[OFF_L +: IDX_W];
      tag = {{(TAG_W-TAGL_W){1'b0}}, va[VA_W-1 -: TAGL_W]};
    end else begin
      idx = va[OFF_S +: IDX_W];
      tag = va[VA_W-1 -: TAG_W];
    end
  end

endmodule

// File: rtl/mtlb_match.sv
module mtlb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 32,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            ent_valid,
  input  logic [WAYS-1:0]            ent_size,
  input  logic [WAYS-1:0][TAG_W-1:0] ent_tag,
  input  logic                       req_size,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any,
  output logic [WAY_W-1:0]           hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = ent_valid[w] && (ent_size[w] == req_size) && (ent_tag[w] == req_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/mtlb_plru.sv
module mtlb_plru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d [SETS];

  // Walk from the root; node n is stored at bit n-1, children are 2n and 2n+1.
  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] t);
    int n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(t[n-1]);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    logic             d;
    int               n;
    r = t;
    n = 1;
    for (int l = 0; l < WAY_W; l++) begin
      d      = w[WAY_W-1-l];
      r[n-1] = ~d;
      n      = 2 * n + int'(d);
    end
    return r;
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tree_d[s] = tree_q[s];
      if (hit_en && hit_set == IDX_W'(s))   tree_d[s] = touch(tree_d[s], hit_way);
      if (fill_en && fill_set == IDX_W'(s)) tree_d[s] = touch(tree_d[s], fill_way);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst) tree_q[s] <= '0;
      else     tree_q[s] <= tree_d[s];
    end
  end

  assign vic_way = pick(tree_q[vic_set]);

  // R8
  plru_avoid_recent_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !hit_en) |=> ((vic_set != $past(fill_set)) || (vic_way != $past(fill_way))));

endmodule

// File: rtl/mtlb_top.sv
module mtlb_top #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int OFF_S = 12,
  parameter int OFF_L = 21,
  parameter int PFN_W = PA_W - OFF_S
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             fill_valid,
  input  logic [VA_W-1:0]  fill_va,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_pa
);
  import mtlb_pkg::*;

  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = VA_W - OFF_S - IDX_W;
  localparam int ENT_W  = 1 + TAG_W + PFN_W;
  localparam int DROP_W = OFF_L - OFF_S;

  // Lookup side decode
  pg_size_e         lk_size;
  logic             lk_rsvd;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;

  // Fill side decode
  pg_size_e         fl_size;
  logic             fl_rsvd;
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;

  mtlb_region_dec #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_S(OFF_S), .OFF_L(OFF_L), .TAG_W(TAG_W))
    u_lk_dec (.va(lk_va), .size(lk_size), .rsvd(lk_rsvd), .idx(lk_idx), .tag(lk_tag));

  mtlb_region_dec #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_S(OFF_S), .OFF_L(OFF_L), .TAG_W(TAG_W))
    u_fl_dec (.va(fill_va), .size(fl_size), .rsvd(fl_rsvd), .idx(fl_idx), .tag(fl_tag));

  // Storage: valid bits in flops (single-cycle flush), payload in per-way RAMs
  logic [WAYS-1:0] valid_q [SETS];

  logic [WAYS-1:0]            lk_ent_size;
  logic [WAYS-1:0][TAG_W-1:0] lk_ent_tag;
  logic [PFN_W-1:0]           lk_ent_pfn [WAYS];
  logic [WAYS-1:0]            fl_ent_size;
  logic [WAYS-1:0][TAG_W-1:0] fl_ent_tag;

  logic             wr_en;
  logic [IDX_W-1:0] wr_set;
  logic [WAY_W-1:0] wr_way;
  logic [ENT_W-1:0] wr_ent;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] mem [SETS];
    logic [ENT_W-1:0] lk_rd;
    logic [ENT_W-1:0] fl_rd;

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w)) mem[wr_set] <= wr_ent;
    end

    assign lk_rd          = mem[lk_idx];
    assign fl_rd          = mem[fl_idx];
    assign lk_ent_size[w] = lk_rd[ENT_W-1];
    assign lk_ent_tag[w]  = lk_rd[PFN_W +: TAG_W];
    assign lk_ent_pfn[w]  = lk_rd[PFN_W-1:0];
    assign fl_ent_size[w] = fl_rd[ENT_W-1];
    assign fl_ent_tag[w]  = fl_rd[PFN_W +: TAG_W];
  end

  // Way compare for lookup and for fill (refresh detection)
  logic [WAYS-1:0]  lk_hit_vec;
  logic             lk_hit_any;
  logic [WAY_W-1:0] lk_hit_way;
  logic [WAYS-1:0]  fl_hit_vec;
  logic             fl_hit_any;
  logic [WAY_W-1:0] fl_hit_way;

  mtlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
    .ent_valid(valid_q[lk_idx]), .ent_size(lk_ent_size), .ent_tag(lk_ent_tag),
    .req_size(lk_size), .req_tag(lk_tag),
    .hit_vec(lk_hit_vec), .hit_any(lk_hit_any), .hit_way(lk_hit_way));

  mtlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
    .ent_valid(valid_q[fl_idx]), .ent_size(fl_ent_size), .ent_tag(fl_ent_tag),
    .req_size(fl_size), .req_tag(fl_tag),
    .hit_vec(fl_hit_vec), .hit_any(fl_hit_any), .hit_way(fl_hit_way));

  // Replacement
  logic             lk_hit;
  logic [WAY_W-1:0] vic_way;

  assign lk_hit = lk_valid && lk_hit_any && !lk_rsvd;

  mtlb_plru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_plru (
    .clk(clk), .rst(rst),
    .hit_en(lk_hit), .hit_set(lk_idx), .hit_way(lk_hit_way),
    .fill_en(wr_en), .fill_set(fl_idx), .fill_way(wr_way),
    .vic_set(fl_idx), .vic_way(vic_way));

  // Fill write path
  assign wr_en  = fill_valid && !fl_rsvd && !flush;
  assign wr_set = fl_idx;
  assign wr_way = fl_hit_any ? fl_hit_way : vic_way;
  assign wr_ent = {fl_size, fl_tag, fill_pfn};

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst || flush)                                valid_q[s] <= '0;
      else if (wr_en && wr_set == IDX_W'(s))           valid_q[s][wr_way] <= 1'b1;
    end
  end

  // Physical address composition
  logic [PFN_W-1:0] hit_pfn;
  logic [PA_W-1:0]  hit_pa;

  always_comb begin
    hit_pfn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) hit_pfn = lk_ent_pfn[w];
    end
    if (lk_size == PG_LARGE) hit_pa = {hit_pfn[PFN_W-1:DROP_W], lk_va[OFF_L-1:0]};
    else                     hit_pa = {hit_pfn, lk_va[OFF_S-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_pa    <= lk_hit ? hit_pa : '0;
    end
  end

  // R1
  rsvd_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_va[VA_W-1 -: 2] == RGN_RESERVED) |=> !rsp_hit);

  // R7
  no_dup_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot0(lk_hit_vec));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(flush)) |=> !rsp_hit);

  // R11
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R3
  big_page_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_size == PG_LARGE) |=> (rsp_pa[OFF_L-1:0] == $past(lk_va[OFF_L-1:0])));

endmodule

// File: tb/mtlb_top_tb_top.sv
module mtlb_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [47:0] lk_va;
  logic        fill_valid;
  logic [47:0] fill_va;
  logic [27:0] fill_pfn;
  logic        flush;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [39:0] rsp_pa;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mtlb_top dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_pfn(fill_pfn),
    .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa));

  // Reference model state
  bit          mv [16][4];
  bit          ms [16][4];
  logic [31:0] mt [16][4];
  logic [27:0] mp [16][4];
  logic [2:0]  mtree [16];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mkva(input logic [1:0] rg, input int idx,
                                       input longint tg, input longint off);
    logic [47:0] v;
    v = {rg, 46'd0};
    if (rg == 2'b10) v = v | (48'(tg) << 25) | (48'(idx) << 21) | (48'(off) & 48'h1F_FFFF);
    else             v = v | (48'(tg) << 16) | (48'(idx) << 12) | (48'(off) & 48'hFFF);
    return v;
  endfunction

  task automatic mdec(input logic [47:0] va, output bit sz, output bit rs,
                      output int idx, output logic [31:0] tg);
    rs  = (va[47:46] == 2'b11);
    sz  = (va[47:46] == 2'b10);
    idx = sz ? int'(va[24:21]) : int'(va[15:12]);
    tg  = sz ? {9'd0, va[47:25]} : va[47:16];
  endtask

  function automatic int mvictim(input int s);
    logic [2:0] t;
    t = mtree[s];
    if (!t[0]) return t[1] ? 1 : 0;
    return t[2] ? 3 : 2;
  endfunction

  task automatic mtouch(input int s, input int w);
    if (w < 2) begin
      mtree[s][0] = 1'b1;
      mtree[s][1] = (w == 0);
    end else begin
      mtree[s][0] = 1'b0;
      mtree[s][2] = (w == 2);
    end
  endtask

  task automatic mlookup(input logic [47:0] va, output bit hit, output int way,
                         output logic [39:0] pa);
    bit sz, rs;
    int idx;
    logic [31:0] tg;
    mdec(va, sz, rs, idx, tg);
    hit = 1'b0; way = 0; pa = '0;
    if (!rs) begin
      for (int w = 0; w < 4; w++) begin
        if (mv[idx][w] && ms[idx][w] == sz && mt[idx][w] == tg) begin
          hit = 1'b1; way = w;
        end
      end
    end
    if (hit) pa = sz ? {mp[idx][way][27:9], va[20:0]} : {mp[idx][way], va[11:0]};
  endtask

  task automatic step(input bit lv, input logic [47:0] lva, input bit fv,
                      input logic [47:0] fva, input logic [27:0] fp, input bit fl,
                      input string req);
    bit eh, fsz, frs, fmatch, lsz, lrs;
    int hw, fidx, fw, lidx;
    logic [31:0] ftg, ltg;
    logic [39:0] ep;
    @(negedge clk);
    lk_valid = lv; lk_va = lva; fill_valid = fv; fill_va = fva; fill_pfn = fp; flush = fl;
    mlookup(lva, eh, hw, ep);
    if (!lv) begin eh = 1'b0; ep = '0; end
    mdec(lva, lsz, lrs, lidx, ltg);
    mdec(fva, fsz, frs, fidx, ftg);
    fmatch = 1'b0; fw = mvictim(fidx);
    for (int w = 0; w < 4; w++) begin
      if (mv[fidx][w] && ms[fidx][w] == fsz && mt[fidx][w] == ftg) begin
        fmatch = 1'b1; fw = w;
      end
    end
    if (eh) mtouch(lidx, hw);
    if (fl) begin
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    end else if (fv && !frs) begin
      mv[fidx][fw] = 1'b1; ms[fidx][fw] = fsz; mt[fidx][fw] = ftg; mp[fidx][fw] = fp;
      mtouch(fidx, fw);
    end
    @(posedge clk);
    #1;
    check(rsp_valid == lv, req, "rsp_valid", 64'(rsp_valid), 64'(lv));
    if (lv) begin
      check(rsp_hit == eh, req, "rsp_hit", 64'(rsp_hit), 64'(eh));
      check(rsp_pa == ep, req, "rsp_pa", 64'(rsp_pa), 64'(ep));
    end
  endtask

  task automatic look(input logic [47:0] va, input string req);
    step(1'b1, va, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic fill(input logic [47:0] va, input logic [27:0] pfn, input string req);
    step(1'b0, '0, 1'b1, va, pfn, 1'b0, req);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] va2, va4;
    for (int s = 0; s < 16; s++) begin
      mtree[s] = '0;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; ms[s][w] = 0; mt[s][w] = '0; mp[s][w] = '0; end
    end
    rst = 1'b1; lk_valid = 0; lk_va = '0; fill_valid = 0; fill_va = '0; fill_pfn = '0; flush = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_pa == 0, "R11", "reset outputs",
          {rsp_valid, rsp_hit, 22'd0, rsp_pa}, 64'd0);
    look(mkva(2'b00, 3, 1, 'h123), "R11 empty after reset");

    // R1/R3: each region code
    fill(mkva(2'b00, 1, 7, 0), 28'hABCDEF1, "R1");
    fill(mkva(2'b01, 1, 7, 0), 28'h1234567, "R1");
    fill(mkva(2'b10, 1, 7, 0), 28'hFEDCBA9, "R1");
    fill(mkva(2'b11, 1, 7, 0), 28'h5555555, "R1 reserved fill");
    look(mkva(2'b00, 1, 7, 'hFED), "R3 small page pa");
    look(mkva(2'b01, 1, 7, 'h001), "R1 region 01 small");
    look(mkva(2'b10, 1, 7, 'h1ABCDE), "R3 large page pa");
    look(mkva(2'b11, 1, 7, 0), "R1 reserved lookup");

    // R2: every set index for both sizes
    for (int i = 0; i < 16; i++) fill(mkva(2'b00, i, 40, 0), 28'(i * 'h111 + 5), "R2");
    for (int i = 0; i < 16; i++) look(mkva(2'b00, i, 40, i * 37), "R2 small index");
    for (int i = 0; i < 16; i++) fill(mkva(2'b10, i, 41, 0), 28'(i * 'h2345 + 9), "R2");
    for (int i = 0; i < 16; i++) look(mkva(2'b10, i, 41, i * 'h1357), "R2 large index");
    look(mkva(2'b00, 2, 41, 0), "R2 wrong tag");

    // R10 flush, and flush beats fill
    step(1'b1, mkva(2'b00, 4, 40, 0), 1'b0, '0, '0, 1'b1, "R10 lookup in flush cycle");
    look(mkva(2'b00, 4, 40, 0), "R10 after flush");
    step(1'b0, '0, 1'b1, mkva(2'b00, 6, 9, 0), 28'h77, 1'b1, "R10 fill with flush");
    look(mkva(2'b00, 6, 9, 0), "R10 fill dropped");

    // R4: aligned tag bits across sizes
    va2 = mkva(2'b10, 3, 'h5A5A5, 0);
    va4 = (48'(va2[47:25]) << 16) | (48'd3 << 12);
    fill(va2, 28'h0ABCDEF, "R4");
    look(va4, "R4 small vs large entry");
    fill(va4, 28'h0111111, "R4");
    look(va4, "R4 small own entry");
    look(va2, "R4 large own entry");

    // R5: mixed sizes in one set
    step(1'b0, '0, 1'b0, '0, '0, 1'b1, "R5");
    fill(mkva(2'b00, 5, 1, 0), 28'h1, "R5");
    fill(mkva(2'b10, 5, 2, 0), 28'h2000, "R5");
    fill(mkva(2'b01, 5, 3, 0), 28'h3, "R5");
    fill(mkva(2'b10, 5, 4, 0), 28'h4000, "R5");
    look(mkva(2'b00, 5, 1, 9), "R5 mixed");
    look(mkva(2'b10, 5, 2, 9), "R5 mixed");
    look(mkva(2'b01, 5, 3, 9), "R5 mixed");
    look(mkva(2'b10, 5, 4, 9), "R5 mixed");

    // R6: same-cycle lookup and fill
    step(1'b1, mkva(2'b00, 8, 12, 4), 1'b1, mkva(2'b00, 8, 12, 0), 28'hC0FFEE, 1'b0, "R6 same cycle");
    look(mkva(2'b00, 8, 12, 4), "R6 next cycle");

    // R7: refill of resident page
    fill(mkva(2'b00, 8, 12, 0), 28'hBEEF00, "R7");
    look(mkva(2'b00, 8, 12, 0), "R7 new pfn");
    fill(mkva(2'b00, 8, 13, 0), 28'h13, "R7");
    fill(mkva(2'b00, 8, 14, 0), 28'h14, "R7");
    fill(mkva(2'b00, 8, 15, 0), 28'h15, "R7");
    for (int t = 12; t < 16; t++) look(mkva(2'b00, 8, t, 0), "R7 no duplicate way");

    // R8/R9: victim order with interleaved hits
    for (int t = 20; t < 30; t++) begin
      fill(mkva(2'b00, 9, t, 0), 28'(t), "R8");
      look(mkva(2'b00, 9, t - 2, 0), "R9 hit touch");
      for (int u = 20; u <= t; u++) look(mkva(2'b00, 9, u, 0), "R8 residency");
    end

    // Random mix against the model
    for (int k = 0; k < 4000; k++) begin
      bit lv, fv, fl;
      lv = ($urandom % 10) < 7;
      fv = ($urandom % 10) < 4;
      fl = ($urandom % 100) == 0;
      step(lv, mkva(2'($urandom % 4), $urandom % 4, $urandom % 6, $urandom),
           fv, mkva(2'($urandom % 4), $urandom % 4, $urandom % 6, 0),
           28'($urandom), fl, "R1 R3 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule